// File: doc/BRIEF.md
# Serial Audio Transmitter with Master and Slave Clocking

This block serialises a stereo pair of 24-bit two's complement samples onto a single data line. Each sample is sent most significant bit first. The line is framed by a bit clock and a channel clock.

In master role the block derives both clocks from its core clock, which runs at 256 times the frame rate. The bit clock is the core clock divided by 4. The channel clock is the core clock divided by 256. In slave role the block keeps those two outputs low. It follows a bit clock and a channel clock supplied from outside, sampling them with the core clock.

A format select picks left-justified framing or I2S-style framing. I2S-style framing delays the word by one bit slot. A new left/right pair is captured only at the start of a frame. The data line stays low after reset until the upstream path flags valid data at a frame start. The role and format selects are captured only while reset is held.

Top module: `audio_serial_tx`

## Requirements
- R1: While `rst_n` is low, `bclk_out`, `lrck_out` and `sdata_out` are all low. This holds immediately, without waiting for a clock edge.
- R2: In master role (`cfg_slave`=0), `bclk_out` has a period of 4 core clocks, high for 2 and low for 2. `lrck_out` has a period of 256 core clocks. `lrck_out` changes only in the cycle where `bclk_out` falls. `lrck_out` stays low until the divider first wraps after reset release.
- R3: In master role, `sdata_out` changes only in the cycle where `bclk_out` falls.
- R4: With `cfg_i2s`=0, the left word is sent while the channel clock is high and the right word while it is low. The MSB occupies the first bit slot after the channel-clock edge, and the 24 bits follow MSB first.
- R5: With `cfg_i2s`=1, the left word is sent while the channel clock is low and the right word while it is high. The first bit slot after the channel-clock edge is low, and the MSB is in the second slot.
- R6: Every bit slot after the last bit of a word, up to the next channel-clock edge, is low.
- R7: After reset, `sdata_out` stays low until a frame start at which `data_valid` is high. From then until the next reset, the line carries data regardless of `data_valid`.
- R8: In slave role (`cfg_slave`=1), data bits change after falling edges of `sbclk_in` and are stable at its rising edges. Frames are delimited by `slrck_in`. Half-frames of 32, 24 or 16 bit periods are accepted, and bits beyond the half-frame length are dropped. `bclk_out` and `lrck_out` stay low.
- R9: `cfg_slave` and `cfg_i2s` are captured only while reset is held. Changes made after reset release have no effect until the next reset.
- R10: The pair on `left_in`/`right_in` is captured only at a frame start. In master role this is the divider wrap; in slave role it is the channel-clock edge that opens the left half. Input changes in mid-frame do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock: 256x frame rate in master role, sampling clock in slave role |
| rst_n | input | 1 | Active-low reset and power-down, asserted asynchronously |
| cfg_slave | input | 1 | Role select: 0 master, 1 slave; captured in reset |
| cfg_i2s | input | 1 | Framing select: 0 left-justified, 1 I2S-style; captured in reset |
| data_valid | input | 1 | Upstream has valid samples; unmutes at a frame start |
| left_in | input | 24 | Left-channel sample, two's complement |
| right_in | input | 24 | Right-channel sample, two's complement |
| sbclk_in | input | 1 | External bit clock used in slave role |
| slrck_in | input | 1 | External channel clock used in slave role |
| bclk_out | output | 1 | Generated bit clock in master role, low in slave role |
| lrck_out | output | 1 | Generated channel clock in master role, low in slave role |
| sdata_out | output | 1 | Serial data, MSB first |

## Verification
The assertions assume that in slave role `sbclk_in` and `slrck_in` change together, on bit-clock falls. They also assume each half period of `sbclk_in` lasts at least six core clocks, so that the synchronised falling edge and the data update land before the next rise. The selects are taken to hold steady from reset assertion until a few cycles after release. The stimulus drives the external clocks one nanosecond after a core-clock falling edge, with eight-clock half periods. It changes the selects only inside reset, except in the single case that checks they are ignored, where it waits four cycles after release first.

// File: rtl/ast_pkg.sv
package ast_pkg;
  typedef enum logic {
    FMT_LJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;

  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/ast_rst_sync.sv
module ast_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/ast_mclk_div.sv
module ast_mclk_div #(
  parameter int MCLK_PER_BIT = 4,
  parameter int SLOT_W       = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  output logic                      bclk_nxt,
  output logic                      half_nxt,
  output logic [$clog2(SLOT_W)-1:0] pos_nxt,
  output logic                      run_nxt,
  output logic                      load
);
  localparam int LOG_MPB = $clog2(MCLK_PER_BIT);
  localparam int POS_W   = $clog2(SLOT_W);
  localparam int DIV_W   = LOG_MPB + POS_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    load  = 1'b0;
    if (en) begin
      cnt_d = cnt_q + 1'b1;
      load  = (cnt_q == '1);
      run_d = run_q | load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign bclk_nxt = cnt_d[LOG_MPB-1];
  assign pos_nxt  = cnt_d[DIV_W-2:LOG_MPB];
  assign half_nxt = cnt_d[DIV_W-1];
  assign run_nxt  = run_d;
endmodule

// File: rtl/ast_slave_follow.sv
module ast_slave_follow #(
  parameter int SLOT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      sbclk,
  input  logic                      slrck,
  input  logic                      left_lvl,
  output logic [$clog2(SLOT_W)-1:0] pos_nxt,
  output logic                      half_nxt,
  output logic                      load
);
  localparam int POS_W = $clog2(SLOT_W);

  logic [1:0]       bsync_q, lsync_q;
  logic             bprev_q, lrprev_q, lrprev_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             half_q, half_d;
  logic             fall;

  assign fall = en & bprev_q & ~bsync_q[1];

  always_comb begin
    pos_d    = pos_q;
    half_d   = half_q;
    lrprev_d = lrprev_q;
    load     = 1'b0;
    if (fall) begin
      lrprev_d = lsync_q[1];
      if (lsync_q[1] != lrprev_q) begin
        pos_d  = '0;
        half_d = (lsync_q[1] != left_lvl);
        load   = ~half_d;
      end else if (pos_q != '1) begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync_q  <= '0;
      lsync_q  <= '0;
      bprev_q  <= 1'b0;
      lrprev_q <= 1'b0;
      pos_q    <= '1;
      half_q   <= 1'b1;
    end else begin
      bsync_q  <= {bsync_q[0], sbclk};
      lsync_q  <= {lsync_q[0], slrck};
      bprev_q  <= bsync_q[1];
      lrprev_q <= lrprev_d;
      pos_q    <= pos_d;
      half_q   <= half_d;
    end
  end

  assign pos_nxt  = pos_d;
  assign half_nxt = half_d;
endmodule

// File: rtl/ast_slot_map.sv
module ast_slot_map #(
  parameter int WORD_W = 24,
  parameter int SLOT_W = 32
) (
  input  logic [$clog2(SLOT_W)-1:0] pos,
  input  logic                      half,
  input  logic                      i2s,
  input  logic [WORD_W-1:0]         word_l,
  input  logic [WORD_W-1:0]         word_r,
  output logic                      bit_o
);
  localparam int POS_W = $clog2(SLOT_W);

  logic [WORD_W-1:0] word;
  logic [POS_W-1:0]  idx;

  always_comb begin
    word  = half ? word_r : word_l;
    idx   = pos - {{(POS_W-1){1'b0}}, i2s};
    bit_o = 1'b0;
    if (!(i2s && (pos == '0))) begin
      for (int k = 0; k < WORD_W; k++) begin
        if ({1'b0, idx} == (POS_W+1)'(k)) bit_o = word[WORD_W-1-k];
      end
    end
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import ast_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int SLOT_W       = 32,
  parameter int MCLK_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slave,
  input  logic              cfg_i2s,
  input  logic              data_valid,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  input  logic              sbclk_in,
  input  logic              slrck_in,
  output logic              bclk_out,
  output logic              lrck_out,
  output logic              sdata_out
);
  localparam int POS_W = $clog2(SLOT_W);

  logic       rstn_s;
  role_e      role_q;
  fmt_e       fmt_q;
  logic       is_slave, is_i2s;

  logic             m_bclk, m_half, m_run, m_load;
  logic [POS_W-1:0] m_pos;
  logic             s_half, s_load;
  logic [POS_W-1:0] s_pos;

  logic [POS_W-1:0]  pos_sel;
  logic              half_sel, load_sel;
  logic [WORD_W-1:0] pl_q, pl_d, pr_q, pr_d;
  logic              live_q, live_d;
  logic              map_bit;
  logic              bclk_d, lrck_d, sd_d;

  ast_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rstn_s)
  );

  // Role and framing are captured only while the block is held in reset.
  always_ff @(posedge clk) begin
    if (!rstn_s) begin
      role_q <= role_e'(cfg_slave);
      fmt_q  <= fmt_e'(cfg_i2s);
    end
  end

  assign is_slave = (role_q == ROLE_SLAVE);
  assign is_i2s   = (fmt_q == FMT_I2S);

  ast_mclk_div #(.MCLK_PER_BIT(MCLK_PER_BIT), .SLOT_W(SLOT_W)) u_div (
    .clk      (clk),
    .rst_n    (rstn_s),
    .en       (~is_slave),
    .bclk_nxt (m_bclk),
    .half_nxt (m_half),
    .pos_nxt  (m_pos),
    .run_nxt  (m_run),
    .load     (m_load)
  );

  ast_slave_follow #(.SLOT_W(SLOT_W)) u_follow (
    .clk      (clk),
    .rst_n    (rstn_s),
    .en       (is_slave),
    .sbclk    (sbclk_in),
    .slrck    (slrck_in),
    .left_lvl (~is_i2s),
    .pos_nxt  (s_pos),
    .half_nxt (s_half),
    .load     (s_load)
  );

  assign pos_sel  = is_slave ? s_pos  : m_pos;
  assign half_sel = is_slave ? s_half : m_half;
  assign load_sel = is_slave ? s_load : m_load;

  // Frame-start capture of the sample pair and of the unmute condition.
  always_comb begin
    pl_d   = pl_q;
    pr_d   = pr_q;
    live_d = live_q;
    if (load_sel) begin
      pl_d   = left_in;
      pr_d   = right_in;
      live_d = live_q | data_valid;
    end
  end

  ast_slot_map #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_map (
    .pos    (pos_sel),
    .half   (half_sel),
    .i2s    (is_i2s),
    .word_l (pl_d),
    .word_r (pr_d),
    .bit_o  (map_bit)
  );

  assign bclk_d = ~is_slave & m_bclk;
  assign lrck_d = ~is_slave & m_run & (m_half ^ ~is_i2s);
  assign sd_d   = live_d & map_bit;

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      pl_q      <= '0;
      pr_q      <= '0;
      live_q    <= 1'b0;
      bclk_out  <= 1'b0;
      lrck_out  <= 1'b0;
      sdata_out <= 1'b0;
    end else begin
      pl_q      <= pl_d;
      pr_q      <= pr_d;
      live_q    <= live_d;
      bclk_out  <= bclk_d;
      lrck_out  <= lrck_d;
      sdata_out <= sd_d;
    end
  end
endmodule

// File: rtl/ast_tx_checker.sv
module ast_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic role_slave,
  input logic fmt_i2s,
  input logic data_valid,
  input logic bclk_out,
  input logic lrck_out,
  input logic sdata_out
);
  logic seen_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_valid <= 1'b0;
    else if (data_valid) seen_valid <= 1'b1;
  end

  // R1: outputs low throughout reset
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      p_reset_quiet_r1: assert (!bclk_out && !lrck_out && !sdata_out)
        else $error("outputs active during reset");
    end
  end

  p_bclk_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_slave && $rose(bclk_out)) |=> (bclk_out ##1 !bclk_out));

  p_lrck_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_slave && !$stable(lrck_out)) |-> $fell(bclk_out));

  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_slave && !$stable(sdata_out)) |-> $fell(bclk_out));

  p_muted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_valid |-> !sdata_out);

  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    role_slave |-> (!bclk_out && !lrck_out));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
      |-> ($stable(role_slave) && $stable(fmt_i2s)));
endmodule

bind audio_serial_tx ast_tx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .role_slave (is_slave),
  .fmt_i2s    (is_i2s),
  .data_valid (data_valid),
  .bclk_out   (bclk_out),
  .lrck_out   (lrck_out),
  .sdata_out  (sdata_out)
);

// File: tb/tb_audio_serial_tx.sv
module tb_audio_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SB    = 8;
  localparam int NVEC       = 7;

  // fields: slave, i2s, bits per half (6), left (24), right (24)
  localparam logic [55:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 6'd32, 24'h800001, 24'h7FFFFE},
    {1'b0, 1'b1, 6'd32, 24'hA5C3F0, 24'h123456},
    {1'b1, 1'b0, 6'd32, 24'hFEDCBA, 24'h000001},
    {1'b1, 1'b1, 6'd32, 24'h5A5A5A, 24'hC0FFEE},
    {1'b1, 1'b0, 6'd24, 24'h13579B, 24'hECA864},
    {1'b1, 1'b0, 6'd16, 24'hBEEF12, 24'h4321AB},
    {1'b1, 1'b1, 6'd24, 24'h777777, 24'h888888}
  };

  logic        clk = 1'b0;
  logic        rst_n, cfg_slave, cfg_i2s, data_valid, sbclk_in, slrck_in;
  logic [23:0] left_in, right_in;
  logic        bclk_out, lrck_out, sdata_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic cur_slave = 1'b0;
  logic cur_i2s   = 1'b0;

  // receiver state
  logic [31:0] sh = '0, rx_l = '0, rx_r = '0;
  int          nbits = 0;
  logic        rb_prev = 1'b0, rl_prev = 1'b0;
  int          cyc = 0, last_b = 0, last_l = 0, bclk_per = 0, lr_per = 0;
  logic        mb_prev = 1'b0, ml_prev = 1'b0;
  int          sd_ones = 0, mst_hi = 0;

  audio_serial_tx dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_slave  (cfg_slave),
    .cfg_i2s    (cfg_i2s),
    .data_valid (data_valid),
    .left_in    (left_in),
    .right_in   (right_in),
    .sbclk_in   (sbclk_in),
    .slrck_in   (slrck_in),
    .bclk_out   (bclk_out),
    .lrck_out   (lrck_out),
    .sdata_out  (sdata_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_slot(input logic [23:0] w, input logic i2s, input int n);
    logic [31:0] full;
    full = i2s ? {1'b0, w, 7'b0} : {w, 8'b0};
    return full >> (32 - n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural receiver and clock monitors, sampled on falling core-clock edges.
  always @(negedge clk) begin
    logic rb, rl;
    cyc++;
    rb = cur_slave ? sbclk_in : bclk_out;
    rl = cur_slave ? slrck_in : lrck_out;
    if (rb && !rb_prev) begin
      if (rl != rl_prev) begin
        if (rl_prev == ~cur_i2s) rx_l = sh;
        else                     rx_r = sh;
        sh    = {31'b0, sdata_out};
        nbits = 1;
      end else begin
        sh = {sh[30:0], sdata_out};
        if (nbits < 32) nbits++;
      end
      rl_prev = rl;
    end
    rb_prev = rb;
    if (bclk_out && !mb_prev) begin bclk_per = cyc - last_b; last_b = cyc; end
    if (lrck_out && !ml_prev) begin lr_per = cyc - last_l; last_l = cyc; end
    mb_prev = bclk_out;
    ml_prev = lrck_out;
    if (sdata_out) sd_ones++;
    if (bclk_out || lrck_out) mst_hi++;
  end

  task automatic do_reset(input logic slave, input logic i2s);
    @(negedge clk);
    rst_n     = 1'b0;
    cfg_slave = slave;
    cfg_i2s   = i2s;
    cur_slave = slave;
    cur_i2s   = i2s;
    sbclk_in  = 1'b1;
    slrck_in  = i2s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic slave_frames(input int nfr, input int bph);
    logic lv;
    lv = ~cur_i2s;
    @(negedge clk); #1;
    for (int f = 0; f < nfr; f++) begin
      for (int h = 0; h < 2; h++) begin
        for (int b = 0; b < bph; b++) begin
          sbclk_in = 1'b0;
          if (b == 0) slrck_in = (h == 0) ? lv : ~lv;
          repeat (HALF_SB) @(negedge clk); #1;
          sbclk_in = 1'b1;
          repeat (HALF_SB) @(negedge clk); #1;
        end
      end
    end
  endtask

  task automatic wait_left_start();
    logic lp;
    lp = lrck_out;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (lrck_out && !lp) break;
      lp = lrck_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..R10 run hung actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [55:0] v;
    string       tag;
    rst_n = 1'b0; cfg_slave = 1'b0; cfg_i2s = 1'b0; data_valid = 1'b0;
    left_in = '0; right_in = '0; sbclk_in = 1'b1; slrck_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", {29'b0, bclk_out, lrck_out, sdata_out}, 32'h0);

    // table walk: framing in both roles and half-frame lengths
    for (int i = 0; i < NVEC; i++) begin
      int bph;
      v = VEC[i];
      bph = int'(v[53:48]);
      left_in = v[47:24]; right_in = v[23:0]; data_valid = 1'b1;
      do_reset(v[55], v[54]);
      mst_hi = 0;
      if (!v[55]) repeat (4*256 + 40) @(negedge clk);
      else        slave_frames(4, bph);
      tag = {v[54] ? "R5" : "R4", " R6", v[55] ? " R8" : " R3"};
      chk({tag, " left word"},  rx_l, exp_slot(v[47:24], v[54], bph));
      chk({tag, " right word"}, rx_r, exp_slot(v[23:0],  v[54], bph));
      if (v[55]) chk("R8 generated clocks held low", 32'(mst_hi), 32'h0);
      if (i == 0) begin
        chk("R2 bit clock period", 32'(bclk_per), 32'd4);
        chk("R2 channel clock period", 32'(lr_per), 32'd256);
      end
    end

    // R7: muted until valid at a frame start, then stays live
    left_in = 24'hFFFFFF; right_in = 24'hF0F0F0; data_valid = 1'b0;
    do_reset(1'b0, 1'b0);
    sd_ones = 0;
    repeat (3*256) @(negedge clk);
    chk("R7 line low before valid", 32'(sd_ones), 32'h0);
    data_valid = 1'b1;
    repeat (300) @(negedge clk);
    data_valid = 1'b0;
    repeat (3*256) @(negedge clk);
    chk("R7 live after valid dropped", rx_l, exp_slot(24'hFFFFFF, 1'b0, 32));

    // R9: selects changed after release are ignored
    left_in = 24'h3C3C3C; right_in = 24'h0F1E2D; data_valid = 1'b1;
    do_reset(1'b0, 1'b0);
    cfg_i2s = 1'b1; cfg_slave = 1'b1;
    repeat (4*256 + 40) @(negedge clk);
    chk("R9 left framing kept", rx_l, exp_slot(24'h3C3C3C, 1'b0, 32));
    chk("R9 right framing kept", rx_r, exp_slot(24'h0F1E2D, 1'b0, 32));

    // R10: mid-frame input change does not tear the frame in flight
    left_in = 24'h111111; right_in = 24'h222222; data_valid = 1'b1;
    do_reset(1'b0, 1'b0);
    repeat (3*256) @(negedge clk);
    wait_left_start();
    repeat (40) @(negedge clk);
    left_in = 24'h999999; right_in = 24'hAAAAAA;
    wait_left_start();
    repeat (8) @(negedge clk);
    chk("R10 right word of in-flight frame", rx_r, exp_slot(24'h222222, 1'b0, 32));
    repeat (200) @(negedge clk);
    chk("R10 next frame takes new left word", rx_l, exp_slot(24'h999999, 1'b0, 32));

    // R1: reset asserted mid-stream clears outputs at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 outputs cleared on reset", {29'b0, bclk_out, lrck_out, sdata_out}, 32'h0);
    repeat (5) @(negedge clk);
    chk("R1 outputs held low in reset", {29'b0, bclk_out, lrck_out, sdata_out}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule